// File: doc/BRIEF.md
# Two-Stage Fetch-Execute Instruction Sequencer

This block is the front end of a small microcontroller core whose instructions are 16 bits wide. Each cycle it fetches one program word and, in the same cycle, hands the word fetched one cycle earlier to the execute stage, so one instruction finishes per cycle in steady state. Some operations need more than 16 bits: a memory-to-memory move, a pointer load with a literal, a subroutine call and a jump. These span two consecutive words. The sequencer holds the first word for one cycle and presents the complete instruction, with both words' operand fields merged, in the cycle that follows.

The block owns the program counter. A call or jump is redirected by the sequencer itself. A computed branch comes from execute as a request with a target. An interrupt request is taken only at an instruction boundary and loads a fixed vector address. Every change of flow throws away the word already prefetched, which leaves one bubble cycle. A continuation word whose upper nibble is all ones does nothing when it is reached on its own.

Program memory is read asynchronously. `pm_data` must hold the word at `pm_addr` within the same cycle.

Top module: `fetch_exec_seq`

## Requirements
- R1: In the cycle after reset is released, `pm_addr` is 0 and `ex_issue` is 0 with `ex_kind` NOP. The word at address 0 issues in the next cycle.
- R2: When the flow does not change, `pm_addr` rises by one each cycle. The word fetched at address a is presented on `ex_word` in the cycle after it was fetched.
- R3: Instruction classes and their encodings:
  - a word with bits 15:12 = 4'hC starts a move;
  - a word with bits 15:6 = 10'b1110111000 starts a pointer load;
  - a word with bits 15:8 = 8'hEC starts a call;
  - a word with bits 15:8 = 8'hEF starts a jump;
  - a word with bits 15:12 = 4'hF is a continuation word;
  - any other word is a single-word instruction, reported with `ex_kind` = 1.
  - The `ex_kind` codes are NOP=0, SINGLE=1, MOVE=2, PTRLOAD=3, CALL=4, JUMP=5.
- R4: A two-word instruction has `ex_issue`=0 and `ex_kind`=NOP in its first cycle. In its second cycle `ex_issue`=1, `ex_word` is the first word, and `ex_kind` is the class. For a move, `ex_opa` is the first word's bits 11:0 (source) and `ex_opb` is the second word's bits 11:0 (destination).
- R5: For a pointer load, `ex_opa` is {first[3:0], second[7:0]} (12-bit literal) and `ex_opb` is first[5:4] zero-extended (pointer select).
- R6: A call or jump shows `ex_target` = {second[11:0], first[7:0]} in its second cycle. The next cycle fetches that target with `ex_issue`=0. The word at the target issues in the cycle after that.
- R7: A continuation word executed on its own, whether reached in sequence or by a branch, issues as NOP (`ex_issue`=1, `ex_kind`=0).
- R8: `br_req` in a cycle with `ex_issue`=1 moves `pm_addr` to `br_target` in the next cycle, followed by one bubble. `br_req` has no effect in a cycle with `ex_issue`=0.
- R9: An accepted interrupt pulses `irq_ack` and reports `irq_ret` equal to the current `pm_addr`. The next cycle fetches `VEC_ADDR` (default 20'h00020) with `ex_issue`=0.
- R10: An interrupt raised during the first cycle of a two-word instruction is not accepted until the cycle in which the second word issues.
- R11: An interrupt raised in a cycle that redirects the flow is accepted in the following bubble cycle, with `irq_ret` equal to the redirect target.
- R12: When a call or jump completes in the same cycle as a `br_req`, the call or jump target wins and `br_req` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pm_addr | output | ADDR_W | Program memory word address (the program counter) |
| pm_data | input | 16 | Word read at pm_addr in the same cycle |
| irq_req | input | 1 | Interrupt request, level |
| br_req | input | 1 | Branch request from execute |
| br_target | input | ADDR_W | Branch destination |
| ex_issue | output | 1 | An instruction completes execution this cycle |
| ex_kind | output | 3 | Instruction class code |
| ex_word | output | 16 | Executing word (first word for two-word instructions) |
| ex_opa | output | 12 | Source address or pointer literal |
| ex_opb | output | 12 | Destination address or pointer select |
| ex_target | output | ADDR_W | Call or jump destination |
| irq_ack | output | 1 | Interrupt accepted this cycle |
| irq_ret | output | ADDR_W | Return address for the accepted interrupt |

## Verification
The embedded properties assume that `pm_data` always returns the word at the current `pm_addr` in the same cycle. The bench meets this by modelling program memory as a combinational function of the address. The properties assume nothing about `br_req` or `irq_req`, because the sequencer gates both itself. The bench therefore raises branch requests in bubble cycles and in call-completion cycles to show that they are ignored. It holds interrupt requests as levels across the first word of a two-word instruction and across a redirect cycle, and drops each one only after it is acknowledged.

// File: rtl/fx_pkg.sv
package fx_pkg;

  localparam int WORD_W = 16;
  localparam int OPND_W = 12;
  localparam int TGT_W  = 20;
  localparam int SEL_W  = 2;

  typedef enum logic [2:0] {
    K_NOP    = 3'd0,
    K_SINGLE = 3'd1,
    K_MOVE   = 3'd2,
    K_LDPTR  = 3'd3,
    K_CALL   = 3'd4,
    K_JUMP   = 3'd5
  } fx_kind_e;

  function automatic logic is_ext(input logic [WORD_W-1:0] w);
    return w[15:12] == 4'hF;
  endfunction

  function automatic logic is_move(input logic [WORD_W-1:0] w);
    return w[15:12] == 4'hC;
  endfunction

  function automatic logic is_ldptr(input logic [WORD_W-1:0] w);
    return w[15:6] == 10'b1110_1110_00;
  endfunction

  function automatic logic is_call(input logic [WORD_W-1:0] w);
    return w[15:8] == 8'hEC;
  endfunction

  function automatic logic is_jump(input logic [WORD_W-1:0] w);
    return w[15:8] == 8'hEF;
  endfunction

  function automatic logic is_dw(input logic [WORD_W-1:0] w);
    return is_move(w) | is_ldptr(w) | is_call(w) | is_jump(w);
  endfunction

  // Class of a leading word; anything that is not a two-word head is SINGLE.
  function automatic fx_kind_e head_kind(input logic [WORD_W-1:0] w);
    if (is_move(w))       return K_MOVE;
    else if (is_ldptr(w)) return K_LDPTR;
    else if (is_call(w))  return K_CALL;
    else if (is_jump(w))  return K_JUMP;
    else                  return K_SINGLE;
  endfunction

  function automatic logic [TGT_W-1:0] jump_target(input logic [WORD_W-1:0] w1,
                                                   input logic [WORD_W-1:0] w2);
    return {w2[11:0], w1[7:0]};
  endfunction

  function automatic logic [OPND_W-1:0] ptr_literal(input logic [WORD_W-1:0] w1,
                                                    input logic [WORD_W-1:0] w2);
    return {w1[3:0], w2[7:0]};
  endfunction

  function automatic logic [SEL_W-1:0] ptr_select(input logic [WORD_W-1:0] w1);
    return w1[5:4];
  endfunction

endpackage

// File: rtl/fx_pipe_reg.sv
module fx_pipe_reg
  import fx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] pm_data,
  input  logic              flush,
  input  logic              phase_a,
  output logic [WORD_W-1:0] ir,
  output logic              ir_ok,
  output logic              dw2,
  output logic [WORD_W-1:0] first_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ir      <= '0;
      ir_ok   <= 1'b0;
      dw2     <= 1'b0;
      first_q <= '0;
    end else begin
      ir    <= pm_data;
      ir_ok <= ~flush;
      dw2   <= phase_a & ~flush;
      if (phase_a) first_q <= ir;
    end
  end

  // R4: the held leading word does not move while its partner executes
  p_head_held_r4: assert property (@(posedge clk) disable iff (rst)
    dw2 |=> (first_q == $past(first_q)));

endmodule

// File: rtl/fx_decode.sv
module fx_decode
  import fx_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] ir,
  input  logic              ir_ok,
  input  logic              dw2,
  input  logic [WORD_W-1:0] first_q,
  output logic              phase_a,
  output logic              issue,
  output logic              xfer,
  output fx_kind_e          kind,
  output logic [WORD_W-1:0] word,
  output logic [OPND_W-1:0] opa,
  output logic [OPND_W-1:0] opb,
  output logic [ADDR_W-1:0] tgt
);

  fx_kind_e head_k;

  assign head_k  = head_kind(first_q);
  assign phase_a = ir_ok & ~dw2 & is_dw(ir);
  assign issue   = ir_ok & ~phase_a;
  assign xfer    = dw2 & ((head_k == K_CALL) | (head_k == K_JUMP));

  always_comb begin
    kind = K_NOP;
    opa  = '0;
    opb  = '0;
    tgt  = '0;
    word = ir_ok ? ir : '0;
    if (dw2) begin
      word = first_q;
      kind = head_k;
      case (head_k)
        K_MOVE: begin
          opa = first_q[OPND_W-1:0];
          opb = ir[OPND_W-1:0];
        end
        K_LDPTR: begin
          opa = ptr_literal(first_q, ir);
          opb = {{(OPND_W-SEL_W){1'b0}}, ptr_select(first_q)};
        end
        K_CALL, K_JUMP: tgt = ADDR_W'(jump_target(first_q, ir));
        default: ;
      endcase
    end else if (issue && !is_ext(ir)) begin
      kind = K_SINGLE;
    end
  end

  // R4: a leading word is always followed by the completing cycle
  p_pair_completes_r4: assert property (@(posedge clk) disable iff (rst)
    phase_a |=> (issue && kind != K_NOP && kind != K_SINGLE));

endmodule

// File: rtl/fx_pc_unit.sv
module fx_pc_unit #(
  parameter int              ADDR_W     = 20,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
  parameter logic [ADDR_W-1:0] VEC_ADDR   = 'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              jmp_take,
  input  logic [ADDR_W-1:0] jmp_tgt,
  input  logic              br_take,
  input  logic [ADDR_W-1:0] br_tgt,
  input  logic              irq_take,
  output logic [ADDR_W-1:0] pc
);

  logic [ADDR_W-1:0] pc_nxt;
  logic              seq_step;

  assign seq_step = ~(jmp_take | br_take | irq_take);

  always_comb begin
    if (jmp_take)      pc_nxt = jmp_tgt;
    else if (br_take)  pc_nxt = br_tgt;
    else if (irq_take) pc_nxt = VEC_ADDR;
    else               pc_nxt = pc + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= RESET_ADDR;
    else     pc <= pc_nxt;
  end

  // R2: plain sequencing steps by one word
  p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
    seq_step |=> (pc == $past(pc) + 1'b1));

  // R9: an accepted interrupt lands on the vector
  p_vector_r9: assert property (@(posedge clk) disable iff (rst)
    irq_take |=> (pc == VEC_ADDR));

  // R12: the call/jump target is taken even when a branch asks at once
  p_xfer_wins_r12: assert property (@(posedge clk) disable iff (rst)
    jmp_take |=> (pc == $past(jmp_tgt)));

endmodule

// File: rtl/fetch_exec_seq.sv
module fetch_exec_seq
  import fx_pkg::*;
#(
  parameter int                ADDR_W     = 20,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
  parameter logic [ADDR_W-1:0] VEC_ADDR   = 'h20
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] pm_addr,
  input  logic [15:0]       pm_data,
  input  logic              irq_req,
  input  logic              br_req,
  input  logic [ADDR_W-1:0] br_target,
  output logic              ex_issue,
  output logic [2:0]        ex_kind,
  output logic [15:0]       ex_word,
  output logic [11:0]       ex_opa,
  output logic [11:0]       ex_opb,
  output logic [ADDR_W-1:0] ex_target,
  output logic              irq_ack,
  output logic [ADDR_W-1:0] irq_ret
);

  logic [WORD_W-1:0] ir, first_q;
  logic              ir_ok, dw2, phase_a, xfer;
  logic              jmp_take, br_take, irq_take, flush;
  fx_kind_e          kind;

  fx_pipe_reg u_pipe (
    .clk     (clk),
    .rst     (rst),
    .pm_data (pm_data),
    .flush   (flush),
    .phase_a (phase_a),
    .ir      (ir),
    .ir_ok   (ir_ok),
    .dw2     (dw2),
    .first_q (first_q)
  );

  fx_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk     (clk),
    .rst     (rst),
    .ir      (ir),
    .ir_ok   (ir_ok),
    .dw2     (dw2),
    .first_q (first_q),
    .phase_a (phase_a),
    .issue   (ex_issue),
    .xfer    (xfer),
    .kind    (kind),
    .word    (ex_word),
    .opa     (ex_opa),
    .opb     (ex_opb),
    .tgt     (ex_target)
  );

  // Flow arbitration: call/jump first, then execute's branch, then interrupt.
  assign jmp_take = xfer;
  assign br_take  = br_req & ex_issue & ~xfer;
  assign irq_take = irq_req & ~phase_a & ~jmp_take & ~br_take;
  assign flush    = jmp_take | br_take | irq_take;

  fx_pc_unit #(
    .ADDR_W     (ADDR_W),
    .RESET_ADDR (RESET_ADDR),
    .VEC_ADDR   (VEC_ADDR)
  ) u_pc (
    .clk      (clk),
    .rst      (rst),
    .jmp_take (jmp_take),
    .jmp_tgt  (ex_target),
    .br_take  (br_take),
    .br_tgt   (br_target),
    .irq_take (irq_take),
    .pc       (pm_addr)
  );

  assign ex_kind = kind;
  assign irq_ack = irq_take;
  assign irq_ret = pm_addr;

  // R1: first cycle out of reset is an empty slot at the reset address
  p_reset_bubble_r1: assert property (@(posedge clk)
    (!rst && $past(rst)) |-> (!ex_issue && pm_addr == RESET_ADDR));

  // R8: every change of flow leaves exactly one empty execute slot
  p_flush_bubble_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!ex_issue && ex_kind == 3'd0));

  // R10: a completing two-word instruction was never interrupted mid-way
  p_no_split_r10: assert property (@(posedge clk) disable iff (rst)
    dw2 |-> !$past(irq_ack));

endmodule

// File: tb/fetch_exec_seq_tb.sv
module fetch_exec_seq_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] pm_addr;
  logic [15:0] pm_data;
  logic        irq_req = 1'b0;
  logic        br_req = 1'b0;
  logic [19:0] br_target = '0;
  logic        ex_issue;
  logic [2:0]  ex_kind;
  logic [15:0] ex_word;
  logic [11:0] ex_opa, ex_opb;
  logic [19:0] ex_target;
  logic        irq_ack;
  logic [19:0] irq_ret;

  int nchk = 0;
  int nerr = 0;

  always #10 clk = ~clk;

  // Program image, combinational read.
  function automatic logic [15:0] pmem(input logic [19:0] a);
    case (a)
      20'h00000: return 16'h1000;
      20'h00001: return 16'h1001;
      20'h00002: return 16'hC123;
      20'h00003: return 16'hF456;
      20'h00004: return 16'hEE2A;
      20'h00005: return 16'hF0BC;
      20'h00006: return 16'h1006;
      20'h00007: return 16'hF777;
      20'h00008: return 16'hEC40;
      20'h00009: return 16'hF001;
      20'h00150: return 16'hEF00;
      20'h00151: return 16'hF003;
      default:   return 16'h2000 | {4'h0, a[11:0]};
    endcase
  endfunction

  assign pm_data = pmem(pm_addr);

  fetch_exec_seq u_dut (
    .clk(clk), .rst(rst), .pm_addr(pm_addr), .pm_data(pm_data),
    .irq_req(irq_req), .br_req(br_req), .br_target(br_target),
    .ex_issue(ex_issue), .ex_kind(ex_kind), .ex_word(ex_word),
    .ex_opa(ex_opa), .ex_opb(ex_opb), .ex_target(ex_target),
    .irq_ack(irq_ack), .irq_ret(irq_ret)
  );

  typedef struct packed {
    logic        br;
    logic [19:0] btgt;
    logic [19:0] addr;
    logic        iss;
    logic [2:0]  kind;
    logic [15:0] word;
    logic [11:0] opa;
    logic [11:0] opb;
    logic [19:0] tgt;
  } row_t;

  // Cycles after reset release; kind codes NOP0 SINGLE1 MOVE2 PTRLOAD3 CALL4 JUMP5.
  localparam row_t TBL [18] = '{
    '{1'b0, 20'h0,   20'h000, 1'b0, 3'd0, 16'h0,    12'h0,   12'h0,   20'h0},
    '{1'b0, 20'h0,   20'h001, 1'b1, 3'd1, 16'h1000, 12'h0,   12'h0,   20'h0},
    '{1'b0, 20'h0,   20'h002, 1'b1, 3'd1, 16'h1001, 12'h0,   12'h0,   20'h0},
    '{1'b0, 20'h0,   20'h003, 1'b0, 3'd0, 16'h0,    12'h0,   12'h0,   20'h0},
    '{1'b0, 20'h0,   20'h004, 1'b1, 3'd2, 16'hC123, 12'h123, 12'h456, 20'h0},
    '{1'b0, 20'h0,   20'h005, 1'b0, 3'd0, 16'h0,    12'h0,   12'h0,   20'h0},
    '{1'b0, 20'h0,   20'h006, 1'b1, 3'd3, 16'hEE2A, 12'hABC, 12'h002, 20'h0},
    '{1'b0, 20'h0,   20'h007, 1'b1, 3'd1, 16'h1006, 12'h0,   12'h0,   20'h0},
    '{1'b0, 20'h0,   20'h008, 1'b1, 3'd0, 16'hF777, 12'h0,   12'h0,   20'h0},
    '{1'b0, 20'h0,   20'h009, 1'b0, 3'd0, 16'h0,    12'h0,   12'h0,   20'h0},
    '{1'b0, 20'h0,   20'h00A, 1'b1, 3'd4, 16'hEC40, 12'h0,   12'h0,   20'h140},
    '{1'b1, 20'h3FF, 20'h140, 1'b0, 3'd0, 16'h0,    12'h0,   12'h0,   20'h0},
    '{1'b1, 20'h150, 20'h141, 1'b1, 3'd1, 16'h2140, 12'h0,   12'h0,   20'h0},
    '{1'b0, 20'h0,   20'h150, 1'b0, 3'd0, 16'h0,    12'h0,   12'h0,   20'h0},
    '{1'b0, 20'h0,   20'h151, 1'b0, 3'd0, 16'h0,    12'h0,   12'h0,   20'h0},
    '{1'b1, 20'h200, 20'h152, 1'b1, 3'd5, 16'hEF00, 12'h0,   12'h0,   20'h300},
    '{1'b0, 20'h0,   20'h300, 1'b0, 3'd0, 16'h0,    12'h0,   12'h0,   20'h0},
    '{1'b0, 20'h0,   20'h301, 1'b1, 3'd1, 16'h2300, 12'h0,   12'h0,   20'h0}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; br_req = 1'b0; irq_req = 1'b0; br_target = '0;
    repeat (2) @(negedge clk);
    @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
  endtask

  // Drive one cycle's inputs, settle, leave the caller to check, then advance.
  task automatic drive(input logic b, input logic [19:0] t, input logic i);
    br_req = b; br_target = t; irq_req = i;
    #2;
  endtask

  task automatic next_cycle();
    @(negedge clk);
  endtask

  task automatic run_plain(input int n);
    for (int k = 0; k < n; k++) begin
      drive(1'b0, '0, 1'b0);
      next_cycle();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    do_reset();
    // Table walk: R1 R2 R3 R4 R5 R6 R7 R8 R12
    for (int c = 0; c < 18; c++) begin
      drive(TBL[c].br, TBL[c].btgt, 1'b0);
      chk("R2", "pm_addr", pm_addr, TBL[c].addr);
      chk("R4", "ex_issue", ex_issue, TBL[c].iss);
      chk("R3", "ex_kind", ex_kind, TBL[c].kind);
      chk("R9", "irq_ack idle", irq_ack, 1'b0);
      if (TBL[c].iss) chk("R2", "ex_word", ex_word, TBL[c].word);
      if (TBL[c].kind == 3'd2 || TBL[c].kind == 3'd3) begin
        chk("R5", "ex_opa", ex_opa, TBL[c].opa);
        chk("R5", "ex_opb", ex_opb, TBL[c].opb);
      end
      if (TBL[c].kind == 3'd4 || TBL[c].kind == 3'd5)
        chk("R6", "ex_target", ex_target, TBL[c].tgt);
      next_cycle();
    end

    // R1: reset in mid-run returns to address 0 with an empty slot
    drive(1'b0, '0, 1'b0);
    do_reset();
    drive(1'b0, '0, 1'b0);
    chk("R1", "pm_addr after reset", pm_addr, 20'h0);
    chk("R1", "issue after reset", ex_issue, 1'b0);
    next_cycle();
    drive(1'b0, '0, 1'b0);
    chk("R1", "first word issues", ex_word, 16'h1000);
    next_cycle();

    // R9: interrupt at an ordinary instruction
    do_reset();
    run_plain(2);
    drive(1'b0, '0, 1'b1);
    chk("R9", "irq_ack", irq_ack, 1'b1);
    chk("R9", "irq_ret", irq_ret, 20'h2);
    chk("R9", "current still issues", ex_word, 16'h1001);
    next_cycle();
    drive(1'b0, '0, 1'b0);
    chk("R9", "vector fetch", pm_addr, 20'h20);
    chk("R9", "bubble after vector", ex_issue, 1'b0);
    next_cycle();
    drive(1'b0, '0, 1'b0);
    chk("R9", "vector word issues", ex_word, 16'h2020);
    next_cycle();

    // R10: interrupt held off through the leading word of a move
    do_reset();
    run_plain(3);
    drive(1'b0, '0, 1'b1);
    chk("R10", "no ack on leading word", irq_ack, 1'b0);
    next_cycle();
    drive(1'b0, '0, 1'b1);
    chk("R10", "ack on completion", irq_ack, 1'b1);
    chk("R10", "move completes", ex_kind, 3'd2);
    chk("R10", "irq_ret past move", irq_ret, 20'h4);
    next_cycle();
    drive(1'b0, '0, 1'b0);
    chk("R10", "vector after move", pm_addr, 20'h20);
    next_cycle();

    // R11: interrupt during a call redirect waits for the bubble
    do_reset();
    run_plain(10);
    drive(1'b0, '0, 1'b1);
    chk("R11", "no ack on call cycle", irq_ack, 1'b0);
    chk("R11", "call completes", ex_kind, 3'd4);
    next_cycle();
    drive(1'b0, '0, 1'b1);
    chk("R11", "ack in bubble", irq_ack, 1'b1);
    chk("R11", "irq_ret is call target", irq_ret, 20'h140);
    next_cycle();
    drive(1'b0, '0, 1'b0);
    chk("R11", "vector after bubble", pm_addr, 20'h20);
    chk("R11", "second bubble", ex_issue, 1'b0);
    next_cycle();

    // R7: continuation word reached by a branch executes as NOP
    do_reset();
    run_plain(1);
    drive(1'b1, 20'h3, 1'b0);
    chk("R8", "branch source issues", ex_issue, 1'b1);
    next_cycle();
    drive(1'b0, '0, 1'b0);
    chk("R8", "branch target fetched", pm_addr, 20'h3);
    chk("R8", "branch bubble", ex_issue, 1'b0);
    next_cycle();
    drive(1'b0, '0, 1'b0);
    chk("R7", "stray word issues", ex_issue, 1'b1);
    chk("R7", "stray word is NOP", ex_kind, 3'd0);
    chk("R7", "stray word value", ex_word, 16'hF456);
    chk("R7", "sequence continues", pm_addr, 20'h4);
    next_cycle();

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule